// File: doc/BRIEF.md
# SPI Master Memory Transaction Sequencer

This block is an SPI master that runs whole memory transactions against a slave device that can report when it is busy. A user requests either a write, giving a 16-bit address, a byte count and a stream of data bytes, or a read, giving a 16-bit address and the number of bytes wanted. The sequencer drives chip select, builds each byte frame and shifts it out in SPI mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge, and bytes are sent most significant bit first. The serial clock is an integer division of the system clock.

A read is split across two chip-select frames. The first frame carries the request. The sequencer then waits until the slave says it is ready, and the second frame clocks out fill bytes to collect the reply. A write also ends with the same wait, so the slave has committed the data before any later transaction can begin. When the slave has no busy line, a fixed delay replaces the polling. A watchdog limits how long a busy poll may last. Between frames, chip select stays high for a minimum idle time. Each received byte is presented with its index and a one-cycle valid strobe.

Top module: `spi_txn_sequencer`

## Requirements
- R1: After a synchronous active-low reset, cs_n is 1 and sck, mosi-unrelated status outputs done, err, rd_valid and active are 0.
- R2: A write request sends one chip-select-low frame of 0x02, addr[15:8], addr[7:0], then wr_len data bytes, where the byte for data index k is taken from wr_data while wr_idx equals k. Each byte goes out MSB first in SPI mode 0, and wr_len = 0 gives a 3-byte frame.
- R3: With busy signalling enabled, a write reports done only after the frame has ended and slave_busy has been sampled at 0 (0 = ready, 1 = busy).
- R4: A read request first sends one chip-select-low frame of exactly four bytes: 0x03, addr[15:8], addr[7:0], rd_len.
- R5: With busy signalling enabled, the data frame of a read starts only after slave_busy has returned to 0 following the request frame. The line is first sampled once the idle gap after that frame has elapsed.
- R6: The data frame sends rd_len bytes of 0xFF. Each byte captured on miso appears on rd_data with a one-cycle rd_valid pulse and rd_index counting 0 to rd_len-1. When rd_len is 0, no data frame is sent and no rd_valid occurs.
- R7: With busy_en = 0, slave_busy is ignored and the sequencer waits delay_cyc clock cycles (plus a fixed gap) between the end of one frame and its next step.
- R8: Between the end of any frame and the start of the next one, cs_n stays high for at least 4*SCK_HALF clock cycles, which is two SCK periods.
- R9: done is a single-cycle pulse at the end of each transaction, and active is high from the cycle after an accepted start until done. A start_wr or start_rd that arrives while active is high is ignored.
- R10: If a busy poll still sees 1 after wd_limit cycles, the transaction is aborted. cs_n stays high, no further frame is sent, err is set together with done, and err is cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_wr | input | 1 | Request a write transaction (sampled while idle, has priority) |
| start_rd | input | 1 | Request a read transaction (sampled while idle) |
| addr | input | 16 | Target memory address |
| wr_len | input | LEN_W | Number of data bytes to write |
| rd_len | input | LEN_W | Number of bytes to read |
| wr_data | input | 8 | Write data for the byte selected by wr_idx |
| wr_idx | output | LEN_W | Index of the write data byte being fetched |
| busy_en | input | 1 | 1: poll slave_busy; 0: use the fixed delay |
| delay_cyc | input | CNT_W | Fixed wait length when busy polling is off |
| wd_limit | input | CNT_W | Maximum busy-poll length before abort |
| sck | output | 1 | SPI serial clock (idles low) |
| mosi | output | 1 | SPI data to the slave |
| miso | input | 1 | SPI data from the slave |
| cs_n | output | 1 | Active-low chip select |
| slave_busy | input | 1 | Slave busy indication, 1 = busy |
| rd_valid | output | 1 | One-cycle strobe for a received read byte |
| rd_data | output | 8 | Received read byte |
| rd_index | output | LEN_W | Position of rd_data within the read |
| active | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Last transaction aborted by the busy watchdog |

## Verification
The hardest case to reach from the ports is the watchdog abort. It happens in the middle of a read, after the request frame has gone out but before any data frame. Reaching it requires a slave that raises its busy line on the frame boundary and then keeps it raised for longer than wd_limit. The bench's slave model raises slave_busy on every rising chip select and holds it for a programmable number of cycles. A long hold combined with a short limit drives the design into the abort. The next transaction, run with a short hold, then shows that err is cleared.

// File: rtl/spi_seq_pkg.sv
// Shared types and protocol constants for the SPI transaction sequencer.
package spi_seq_pkg;

    // Which frame of a transaction is on the wire
    typedef enum logic [1:0] {
        PH_WRITE = 2'd0,
        PH_REQ   = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;

    // What the wait unit is timing
    typedef enum logic [1:0] {
        WK_GAP   = 2'd0,
        WK_BUSY  = 2'd1,
        WK_DELAY = 2'd2
    } wait_kind_e;

    // Top-level sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_GAP   = 3'd3,
        ST_WAIT  = 3'd4
    } state_e;

    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/spi_byte_engine.sv
// Byte shifter and serial clock generator, SPI mode 0, MSB first.
// Assumes: load is pulsed only while the engine is idle; SCK_HALF >= 1 is
// the number of system clocks per half SCK period. done pulses for one
// cycle when the eighth falling edge has been produced; rx_byte then holds
// the full received byte.
module spi_byte_engine #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi
);
    localparam int DIV_W = $clog2(SCK_HALF + 1);

    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;

    // Shift eight bits, toggling sck every SCK_HALF clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sck     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !busy) begin
                busy    <= 1'b1;
                tx_sh   <= tx_byte;
                div_cnt <= '0;
                bit_cnt <= '0;
                sck     <= 1'b0;
            end else if (busy) begin
                if (div_cnt == DIV_W'(SCK_HALF - 1)) begin
                    div_cnt <= '0;
                    if (!sck) begin
                        sck   <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end
        end
    end

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;

    AST_LOAD_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R2
    AST_SCK_IDLES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck); // R2

endmodule

// File: rtl/spi_wait_unit.sv
// Inter-frame timer: minimum idle gap, busy-line poll with watchdog, or a
// fixed delay. Assumes go is a one-cycle pulse; delay and limit are latched
// at go. slave busy is brought in through a two-flop synchronizer.
module spi_wait_unit
    import spi_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int GAP_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  wait_kind_e       kind,
    input  logic [CNT_W-1:0] delay_cyc,
    input  logic [CNT_W-1:0] wd_limit,
    input  logic             busy_in,
    output logic             fin,
    output logic             tmo
);
    logic             busy_m, busy_s;
    logic             running;
    wait_kind_e       kind_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dly_q;
    logic [CNT_W-1:0] wd_q;

    // Synchronize the asynchronous busy line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_m <= 1'b0;
            busy_s <= 1'b0;
        end else begin
            busy_m <= busy_in;
            busy_s <= busy_m;
        end
    end

    // Count the selected wait and report finish or watchdog expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            kind_q  <= WK_GAP;
            cnt     <= '0;
            dly_q   <= '0;
            wd_q    <= '0;
            fin     <= 1'b0;
            tmo     <= 1'b0;
        end else begin
            fin <= 1'b0;
            tmo <= 1'b0;
            if (go) begin
                running <= 1'b1;
                kind_q  <= kind;
                cnt     <= '0;
                dly_q   <= delay_cyc;
                wd_q    <= wd_limit;
            end else if (running) begin
                case (kind_q)
                    WK_GAP: begin
                        if (cnt >= CNT_W'(GAP_CYC - 1)) begin
                            fin     <= 1'b1;
                            running <= 1'b0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    WK_DELAY: begin
                        if (cnt >= dly_q) begin
                            fin     <= 1'b1;
                            running <= 1'b0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    WK_BUSY: begin
                        if (!busy_s) begin
                            fin     <= 1'b1;
                            running <= 1'b0;
                        end else if (cnt >= wd_q) begin
                            tmo     <= 1'b1;
                            running <= 1'b0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: running <= 1'b0;
                endcase
            end
        end
    end

    AST_FIN_TMO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fin && tmo)); // R10
    AST_TMO_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> $past(busy_s)); // R10

endmodule

// File: rtl/spi_byte_select.sv
// Chooses the next byte to shift from the frame kind and byte position.
// Assumes positions 0..2 carry command and address; later positions carry
// write data, the read count, or fill bytes in a data frame.
module spi_byte_select
    import spi_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  phase_e           phase,
    input  logic [LEN_W:0]   idx,
    input  logic [15:0]      addr,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wr_data,
    output logic [7:0]       byte_o,
    output logic [LEN_W-1:0] wr_idx
);
    localparam int IDX_W = LEN_W + 1;

    // Data index is the byte position past the three header bytes
    assign wr_idx = LEN_W'(idx - IDX_W'(3));

    // Map frame position to byte content
    always_comb begin
        byte_o = FILL_BYTE;
        if (phase != PH_DATA) begin
            if (idx == IDX_W'(0)) begin
                byte_o = (phase == PH_WRITE) ? CMD_WRITE : CMD_READ;
            end else if (idx == IDX_W'(1)) begin
                byte_o = addr[15:8];
            end else if (idx == IDX_W'(2)) begin
                byte_o = addr[7:0];
            end else if (phase == PH_WRITE) begin
                byte_o = wr_data;
            end else begin
                byte_o = 8'(len);
            end
        end
    end

endmodule

// File: rtl/spi_txn_sequencer.sv
// SPI master transaction sequencer. Runs write frames, read request frames
// and read data frames, separated by a minimum idle gap and then either a
// busy-line poll (with watchdog) or a fixed delay.
// Assumes: start inputs are sampled only in idle; addr, lengths and the mode
// inputs are captured at start; wr_data follows wr_idx within one cycle.
module spi_txn_sequencer
    import spi_seq_pkg::*;
#(
    parameter int SCK_HALF = 2,
    parameter int LEN_W    = 8,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             start_rd,
    input  logic [15:0]      addr,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [7:0]       wr_data,
    output logic [LEN_W-1:0] wr_idx,
    input  logic             busy_en,
    input  logic [CNT_W-1:0] delay_cyc,
    input  logic [CNT_W-1:0] wd_limit,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n,
    input  logic             slave_busy,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_index,
    output logic             active,
    output logic             done,
    output logic             err
);
    localparam int IDX_W   = LEN_W + 1;
    localparam int GAP_CYC = 4 * SCK_HALF;
    localparam int HC_W    = $clog2(GAP_CYC + 1);

    state_e           st;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [15:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic             busy_mode;
    logic             eng_load;
    logic [7:0]       eng_tx;
    logic             eng_busy;
    logic             eng_done;
    logic [7:0]       eng_rx;
    logic [7:0]       sel_byte;
    logic             wait_go;
    wait_kind_e       wait_kind;
    logic             wait_fin;
    logic             wait_tmo;
    logic [HC_W-1:0]  hi_cnt;

    spi_byte_select #(.LEN_W(LEN_W)) u_sel (
        .phase   (phase),
        .idx     (idx),
        .addr    (addr_q),
        .len     (len_q),
        .wr_data (wr_data),
        .byte_o  (sel_byte),
        .wr_idx  (wr_idx)
    );

    spi_byte_engine #(.SCK_HALF(SCK_HALF)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (eng_load),
        .tx_byte (eng_tx),
        .miso    (miso),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sck     (sck),
        .mosi    (mosi)
    );

    spi_wait_unit #(.CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (wait_go),
        .kind      (wait_kind),
        .delay_cyc (delay_cyc),
        .wd_limit  (wd_limit),
        .busy_in   (slave_busy),
        .fin       (wait_fin),
        .tmo       (wait_tmo)
    );

    // Position of the final byte of the current frame
    always_comb begin
        case (phase)
            PH_WRITE: last_idx = IDX_W'(len_q) + IDX_W'(2);
            PH_REQ:   last_idx = IDX_W'(3);
            default:  last_idx = IDX_W'(len_q) - IDX_W'(1);
        endcase
    end

    // Transaction sequencing: frames, gaps, waits and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            phase     <= PH_WRITE;
            idx       <= '0;
            addr_q    <= '0;
            len_q     <= '0;
            busy_mode <= 1'b0;
            cs_n      <= 1'b1;
            eng_load  <= 1'b0;
            eng_tx    <= '0;
            wait_go   <= 1'b0;
            wait_kind <= WK_GAP;
            done      <= 1'b0;
            err       <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            rd_index  <= '0;
        end else begin
            eng_load <= 1'b0;
            wait_go  <= 1'b0;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_wr || start_rd) begin
                        addr_q    <= addr;
                        len_q     <= start_wr ? wr_len : rd_len;
                        phase     <= start_wr ? PH_WRITE : PH_REQ;
                        busy_mode <= busy_en;
                        err       <= 1'b0;
                        idx       <= '0;
                        cs_n      <= 1'b0;
                        st        <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    eng_load <= 1'b1;
                    eng_tx   <= sel_byte;
                    st       <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (eng_done) begin
                        if (phase == PH_DATA) begin
                            rd_valid <= 1'b1;
                            rd_data  <= eng_rx;
                            rd_index <= LEN_W'(idx);
                        end
                        if (idx == last_idx) begin
                            cs_n      <= 1'b1;
                            wait_go   <= 1'b1;
                            wait_kind <= WK_GAP;
                            st        <= ST_GAP;
                        end else begin
                            idx <= idx + IDX_W'(1);
                            st  <= ST_LOAD;
                        end
                    end
                end
                ST_GAP: begin
                    if (wait_fin) begin
                        if (phase == PH_DATA) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            wait_go   <= 1'b1;
                            wait_kind <= busy_mode ? WK_BUSY : WK_DELAY;
                            st        <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (wait_tmo) begin
                        err  <= 1'b1;
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end else if (wait_fin) begin
                        if (phase == PH_REQ && len_q != '0) begin
                            phase <= PH_DATA;
                            idx   <= '0;
                            cs_n  <= 1'b0;
                            st    <= ST_LOAD;
                        end else begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign active = (st != ST_IDLE);

    // Checker support: saturating count of cycles with chip select high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= HC_W'(GAP_CYC);
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HC_W'(GAP_CYC)) begin
            hi_cnt <= hi_cnt + HC_W'(1);
        end
    end

    AST_CS_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> hi_cnt == HC_W'(GAP_CYC)); // R8
    AST_SCK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R2
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done && cs_n); // R10

endmodule

// File: tb/tb_spi_txn_sequencer.sv
`timescale 1ns/1ps
module tb_spi_txn_sequencer;
    localparam int HALF = 2;
    localparam int GAP  = 4 * HALF;
    localparam int LW   = 8;
    localparam int CW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_wr = 1'b0, start_rd = 1'b0;
    logic [15:0]   addr = '0;
    logic [LW-1:0] wr_len = '0, rd_len = '0;
    logic [7:0]    wr_data;
    logic [LW-1:0] wr_idx;
    logic          busy_en = 1'b1;
    logic [CW-1:0] delay_cyc = '0, wd_limit = 16'd5000;
    logic          sck, mosi, cs_n;
    logic          miso = 1'b0;
    logic          slave_busy = 1'b0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic [LW-1:0] rd_index;
    logic          active, done, err;

    always #10 clk = ~clk;

    spi_txn_sequencer #(.SCK_HALF(HALF), .LEN_W(LW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .addr(addr), .wr_len(wr_len), .rd_len(rd_len), .wr_data(wr_data),
        .wr_idx(wr_idx), .busy_en(busy_en), .delay_cyc(delay_cyc),
        .wd_limit(wd_limit), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .slave_busy(slave_busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_index(rd_index), .active(active),
        .done(done), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] wr_buf [0:15];
    assign wr_data = wr_buf[wr_idx[3:0]];

    function automatic logic [7:0] pat(input int i);
        return 8'h3C ^ 8'(i * 17);
    endfunction

    // Slave model: frame capture and miso generation (mode 0)
    int nfr = 0;
    int cur = 0;
    int sbit = 0;
    logic [7:0] ssh = '0, stx = '0;
    logic [7:0] fb [0:3][0:15];
    int fcnt [0:3];
    int fstart [0:3];
    int fend [0:3];

    always @(negedge cs_n) begin
        cur = (nfr < 4) ? nfr : 3;
        fcnt[cur] = 0;
        fstart[cur] = cyc;
        nfr++;
        sbit = 0;
        stx = pat(0);
        miso = stx[7];
    end
    always @(posedge cs_n) fend[cur] = cyc;
    always @(posedge sck) if (cs_n === 1'b0) begin
        ssh = {ssh[6:0], mosi};
        sbit++;
        if (sbit == 8) begin
            if (fcnt[cur] < 16) fb[cur][fcnt[cur]] = ssh;
            fcnt[cur]++;
            sbit = 0;
        end
    end
    always @(negedge sck) if (cs_n === 1'b0) begin
        if (sbit == 0) stx = pat(fcnt[cur]);
        else stx = {stx[6:0], 1'b0};
        miso = stx[7];
    end

    // Slave busy model: raise on every frame end, hold for busy_hold cycles
    int busy_hold = 40;
    int busy_left = 0;
    int t_blow = -1;
    logic cs_q = 1'b1;
    always @(negedge clk) begin
        if (cs_n === 1'b1 && cs_q === 1'b0) begin
            slave_busy = 1'b1;
            busy_left = busy_hold;
        end else if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) begin
                slave_busy = 1'b0;
                t_blow = cyc;
            end
        end
        cs_q = cs_n;
    end

    // Read-byte capture and idle-gap monitor
    int nrd = 0;
    logic [7:0]    rdv_data [0:15];
    logic [LW-1:0] rdv_idx [0:15];
    int hi_run = 100000;
    int min_gap = 100000;
    always @(negedge clk) begin
        if (rd_valid === 1'b1) begin
            if (nrd < 16) begin
                rdv_data[nrd] = rd_data;
                rdv_idx[nrd] = rd_index;
            end
            nrd++;
        end
        if (cs_n === 1'b1) hi_run++;
        else if (cs_n === 1'b0) begin
            if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input bit wr);
        @(negedge clk);
        start_wr = wr;
        start_rd = !wr;
        @(negedge clk);
        start_wr = 1'b0;
        start_rd = 1'b0;
    endtask

    task automatic wait_done(output int dc);
        int k;
        dc = -1;
        k = 0;
        while (dc < 0 && k < 30000) begin
            @(negedge clk);
            k++;
            if (done === 1'b1) dc = cyc;
        end
        if (dc < 0) chk(1'b0, "R9", "done never seen", 0, 1);
    endtask

    task automatic settle();
        int k;
        k = 0;
        while ((busy_left != 0 || active) && k < 30000) begin
            @(negedge clk);
            k++;
        end
        repeat (5) @(negedge clk);
        nfr = 0;
        nrd = 0;
        t_blow = -1;
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(cs_n === 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);
        chk(sck === 1'b0, "R1", "sck after reset", int'(sck), 0);
        chk(done === 1'b0 && err === 1'b0, "R1", "done/err after reset", int'({done, err}), 0);
        chk(rd_valid === 1'b0 && active === 1'b0, "R1", "rd_valid/active after reset",
            int'({rd_valid, active}), 0);
    endtask

    task automatic test_write(input logic [15:0] a, input int len);
        int dc;
        settle();
        for (int i = 0; i < 16; i++) wr_buf[i] = 8'hA1 + 8'(i * 13);
        busy_en = 1'b1;
        busy_hold = 40;
        addr = a;
        wr_len = LW'(len);
        pulse_start(1'b1);
        wait_done(dc);
        chk(nfr == 1, "R2", "write frame count", nfr, 1);
        chk(fcnt[0] == 3 + len, "R2", "write frame length", fcnt[0], 3 + len);
        chk(fb[0][0] == 8'h02, "R2", "write command", int'(fb[0][0]), 2);
        chk(fb[0][1] == a[15:8] && fb[0][2] == a[7:0], "R2", "write address",
            int'({fb[0][1], fb[0][2]}), int'(a));
        for (int i = 0; i < len; i++)
            chk(fb[0][3+i] == wr_buf[i], "R2", "write data byte", int'(fb[0][3+i]), int'(wr_buf[i]));
        chk(t_blow >= 0 && dc > t_blow, "R3", "write done after busy released", dc, t_blow + 1);
        chk(err === 1'b0, "R3", "write err", int'(err), 0);
    endtask

    task automatic test_read(input logic [15:0] a, input int cnt);
        int dc;
        int tb_snap;
        settle();
        busy_en = 1'b1;
        busy_hold = 40;
        addr = a;
        rd_len = LW'(cnt);
        pulse_start(1'b0);
        wait_done(dc);
        tb_snap = t_blow;
        chk(fcnt[0] == 4, "R4", "request frame length", fcnt[0], 4);
        chk(fb[0][0] == 8'h03 && fb[0][3] == 8'(cnt), "R4", "request cmd/count",
            int'({fb[0][0], fb[0][3]}), int'({8'h03, 8'(cnt)}));
        chk(fb[0][1] == a[15:8] && fb[0][2] == a[7:0], "R4", "request address",
            int'({fb[0][1], fb[0][2]}), int'(a));
        chk(nfr == 2, "R5", "read frame count", nfr, 2);
        chk(tb_snap >= 0 && fstart[1] > tb_snap, "R5", "data frame after busy release",
            fstart[1], tb_snap + 1);
        chk(fstart[1] - fend[0] >= 40, "R5", "data frame waited for busy",
            fstart[1] - fend[0], 40);
        chk(fcnt[1] == cnt, "R6", "data frame length", fcnt[1], cnt);
        for (int i = 0; i < cnt; i++)
            chk(fb[1][i] == 8'hFF, "R6", "fill byte", int'(fb[1][i]), 255);
        chk(nrd == cnt, "R6", "rd_valid count", nrd, cnt);
        for (int i = 0; i < cnt; i++) begin
            chk(rdv_data[i] == pat(i), "R6", "read byte", int'(rdv_data[i]), int'(pat(i)));
            chk(rdv_idx[i] == LW'(i), "R6", "read index", int'(rdv_idx[i]), i);
        end
        chk(err === 1'b0, "R10", "err cleared by accepted start", int'(err), 0);
    endtask

    task automatic test_read_zero();
        int dc;
        settle();
        busy_en = 1'b1;
        busy_hold = 30;
        addr = 16'h0BEE;
        rd_len = '0;
        pulse_start(1'b0);
        wait_done(dc);
        repeat (100) @(negedge clk);
        chk(nfr == 1, "R6", "zero-count read frames", nfr, 1);
        chk(fcnt[0] == 4 && fb[0][3] == 8'h00, "R6", "zero-count request", fcnt[0], 4);
        chk(nrd == 0, "R6", "zero-count rd_valid", nrd, 0);
    endtask

    task automatic test_delay_mode();
        int dc;
        settle();
        busy_en = 1'b0;
        delay_cyc = 16'd50;
        busy_hold = 300;
        addr = 16'h4321;
        rd_len = 8'd2;
        pulse_start(1'b0);
        wait_done(dc);
        chk(nfr == 2, "R7", "delay-mode frames", nfr, 2);
        chk(fstart[1] - fend[0] >= GAP + 50, "R7", "fixed delay lower bound",
            fstart[1] - fend[0], GAP + 50);
        chk(fstart[1] - fend[0] <= GAP + 62, "R7", "busy line ignored",
            fstart[1] - fend[0], GAP + 62);
        chk(nrd == 2 && rdv_data[1] == pat(1), "R7", "delay-mode read data", nrd, 2);
        busy_en = 1'b1;
    endtask

    task automatic test_watchdog();
        int dc;
        settle();
        busy_en = 1'b1;
        wd_limit = 16'd100;
        busy_hold = 2000;
        addr = 16'h00F0;
        rd_len = 8'd4;
        pulse_start(1'b0);
        wait_done(dc);
        chk(err === 1'b1, "R10", "err after watchdog", int'(err), 1);
        chk(dc - fend[0] < 200, "R10", "abort latency", dc - fend[0], 200);
        repeat (50) @(negedge clk);
        chk(nfr == 1 && cs_n === 1'b1, "R10", "no data frame after abort", nfr, 1);
        chk(nrd == 0, "R10", "no read bytes after abort", nrd, 0);
        wd_limit = 16'd5000;
    endtask

    task automatic test_ignore_start();
        int dc;
        settle();
        for (int i = 0; i < 16; i++) wr_buf[i] = 8'h10 + 8'(i);
        busy_en = 1'b1;
        busy_hold = 30;
        addr = 16'h5A5A;
        wr_len = 8'd2;
        pulse_start(1'b1);
        repeat (20) @(negedge clk);
        chk(active === 1'b1, "R9", "active during write", int'(active), 1);
        pulse_start(1'b0);
        wait_done(dc);
        chk(active === 1'b0, "R9", "active low with done", int'(active), 0);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done single cycle", int'(done), 0);
        repeat (150) @(negedge clk);
        chk(nfr == 1 && active === 1'b0, "R9", "start ignored while active", nfr, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_write(16'h1234, 3);
        test_write(16'hBEEF, 0);
        test_read(16'h0456, 4);
        test_read_zero();
        test_delay_mode();
        test_watchdog();
        test_read(16'h7001, 1);
        test_ignore_start();
        settle();
        chk(min_gap >= GAP, "R8", "minimum chip-select idle", min_gap, GAP);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule